// File: doc/BRIEF.md
# I2C Register Access Sequencer

This block turns a single command into a complete register access on an I2C device. A command names a 7-bit device, an internal register address of zero to four bytes, a direction (write, read or probe) and a byte count. The sequencer breaks the access into single-byte jobs and hands each one to a byte-level I2C engine. Each job carries its data byte and its start, stop, NAK-to-send and receive flags, and is launched by a one-cycle trigger. The sequencer then waits for the engine to report completion and checks the acknowledge.

Write payload bytes come in on a valid/ready stream, and read bytes leave on another valid/ready stream. Before each byte, the sequencer waits for the engine's busy flag to clear. Every wait is bounded by a per-byte cycle budget, `TIMEOUT_CYCLES`. At the end it raises `done` for one cycle with a status code, which is zero on success. On any failure it also pulses a unit reset to the engine.

Top module: `i2c_regseq`

## Requirements
- R1: Every read or write access begins with a byte that has the start flag set and data {device, 0}, and that byte must be acknowledged.
- R2: Internal address bytes (count 0 to 4, taken from `cmd_addr`) follow with no start, stop or NAK flag, lowest byte (`cmd_addr[7:0]`) first, and each must be acknowledged.
- R3: A read then sends a repeated-start byte {device, 1} that must be acknowledged. It then receives `cmd_len` bytes with the receive flag set. Every byte except the last has NAK and stop clear; the last has both set.
- R4: A write takes `cmd_len` payload bytes from the write stream, in order. Each must be acknowledged, and only the last carries the stop flag.
- R5: A probe sends a start byte {device, 1} and then receives one byte with NAK and stop set. It reports success only if both complete, and it puts nothing on the read stream.
- R6: A completed transmit byte reported without acknowledge (`eng_ack`=0) stops the access at once with status 3. No further byte is issued.
- R7: No byte is triggered while `eng_busy` is high. If busy stays high for `TIMEOUT_CYCLES` waiting cycles, the access ends with status 6.
- R8: A byte whose completion is seen within the first `TIMEOUT_CYCLES` waiting cycles after its trigger is accepted. Otherwise the access ends with status 2 for a transmit byte or 4 for a receive byte.
- R9: Command direction code 3, or an address length above 4 on a read or write, ends with status 5. A read or write with `cmd_len`=0 ends with status 1. Neither case issues a bus byte. Direction codes are 0 write, 1 read, 2 probe.
- R10: `done` is a one-cycle pulse that carries `status` (0 on success). `eng_unit_rst` pulses in that same cycle exactly when the status is nonzero. After reset the block is idle with `cmd_ready` high and no output active.
- R11: Read bytes appear on the read stream in bus order. While `rd_valid` is high and `rd_ready` is low, the value and its valid flag hold.
- R12: `eng_go` is a single-cycle pulse, so each byte is issued exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and accepting a command |
| cmd_dir | input | 2 | 0 write, 1 read, 2 probe, 3 illegal |
| cmd_dev | input | 7 | Device address |
| cmd_addr | input | 8*MAX_ALEN | Internal address, lowest byte sent first |
| cmd_alen | input | clog2(MAX_ALEN+1) | Internal address byte count |
| cmd_len | input | LEN_W | Payload byte count |
| wr_valid | input | 1 | Write payload byte offered |
| wr_ready | output | 1 | Write payload byte taken |
| wr_data | input | 8 | Write payload byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte consumed |
| rd_data | output | 8 | Read byte |
| eng_go | output | 1 | Trigger for one byte job |
| eng_start | output | 1 | Job begins with a (repeated) start |
| eng_stop | output | 1 | Job ends with a stop |
| eng_nak | output | 1 | Answer a received byte with NAK |
| eng_rd | output | 1 | Job receives a byte |
| eng_wdata | output | 8 | Byte to transmit |
| eng_done | input | 1 | Engine finished the current job |
| eng_ack | input | 1 | Transmitted byte was acknowledged |
| eng_rdata | input | 8 | Received byte |
| eng_busy | input | 1 | Engine busy flag |
| eng_unit_rst | output | 1 | Engine reset pulse after an error |
| done | output | 1 | Access finished |
| status | output | 3 | 0 ok, 1 empty, 2 tx timeout, 3 no ACK, 4 rx timeout, 5 illegal, 6 busy |

## Verification
Byte completion and timeout expiry can fall in the same cycle. This happens on the last cycle of the waiting window, where a completion must win over the timeout. The bench's engine model is set to answer exactly `TIMEOUT_CYCLES` cycles after the trigger, and the access is expected to succeed. One cycle later, it is expected to fail with the transmit or receive timeout code and with an engine reset. The same window governs the busy wait, which is tried both with busy held for the whole window and with busy released inside it.

// File: rtl/i2c_regseq_pkg.sv
package i2c_regseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOADWR,
        ST_BUSYWT,
        ST_ISSUE,
        ST_WAITDN,
        ST_RDOUT,
        ST_FINISH
    } rs_state_e;

    typedef enum logic [2:0] {
        PH_DEVW,
        PH_ADDR,
        PH_DEVR,
        PH_WDATA,
        PH_RDATA
    } rs_phase_e;

    localparam logic [1:0] DIR_WRITE = 2'd0;
    localparam logic [1:0] DIR_READ  = 2'd1;
    localparam logic [1:0] DIR_PROBE = 2'd2;
    localparam logic [1:0] DIR_BAD   = 2'd3;

    localparam logic [2:0] ERR_NONE    = 3'd0;
    localparam logic [2:0] ERR_EMPTY   = 3'd1;
    localparam logic [2:0] ERR_TXTO    = 3'd2;
    localparam logic [2:0] ERR_NOACK   = 3'd3;
    localparam logic [2:0] ERR_RXTO    = 3'd4;
    localparam logic [2:0] ERR_ILLEGAL = 3'd5;
    localparam logic [2:0] ERR_BUSY    = 3'd6;

    typedef struct packed {
        logic [7:0] data;
        logic       start;
        logic       stop;
        logic       nak;
        logic       rd;
    } rs_byte_t;

endpackage

// File: rtl/regseq_timer.sv
module regseq_timer #(
    parameter int LIMIT = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic expired_o
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (restart_i || !run_i) begin
            t_d.cnt = '0;
        end else if (t_q.cnt != LAST) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign expired_o = run_i && (t_q.cnt == LAST);

    AST_TMR_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_i) |-> (t_q.cnt == '0)); // R8

endmodule

// File: rtl/regseq_bytegen.sv
module regseq_bytegen
    import i2c_regseq_pkg::*;
#(
    parameter int MAX_ALEN = 4,
    parameter int ALEN_W   = 3
) (
    input  rs_phase_e                 phase_i,
    input  logic [6:0]                dev_i,
    input  logic [8*MAX_ALEN-1:0]     addr_i,
    input  logic [ALEN_W-1:0]         idx_i,
    input  logic                      last_i,
    input  logic [7:0]                wbyte_i,
    output rs_byte_t                  byte_o
);
    logic [7:0] abytes [MAX_ALEN];

    for (genvar g = 0; g < MAX_ALEN; g++) begin : g_abyte
        assign abytes[g] = addr_i[8*g +: 8];
    end

    always_comb begin
        byte_o = '0;
        unique case (phase_i)
            PH_DEVW: begin
                byte_o.data  = {dev_i, 1'b0};
                byte_o.start = 1'b1;
            end
            PH_ADDR: begin
                byte_o.data = abytes[idx_i];
            end
            PH_DEVR: begin
                byte_o.data  = {dev_i, 1'b1};
                byte_o.start = 1'b1;
            end
            PH_WDATA: begin
                byte_o.data = wbyte_i;
                byte_o.stop = last_i;
            end
            PH_RDATA: begin
                byte_o.rd   = 1'b1;
                byte_o.nak  = last_i;
                byte_o.stop = last_i;
            end
            default: byte_o = '0;
        endcase
    end

endmodule

// File: rtl/regseq_ctrl.sv
module regseq_ctrl
    import i2c_regseq_pkg::*;
#(
    parameter int MAX_ALEN = 4,
    parameter int LEN_W    = 8,
    parameter int ADDR_W   = 32,
    parameter int ALEN_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic [1:0]        cmd_dir_i,
    input  logic [6:0]        cmd_dev_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [ALEN_W-1:0] cmd_alen_i,
    input  logic [LEN_W-1:0]  cmd_len_i,
    input  logic              wr_valid_i,
    output logic              wr_ready_o,
    input  logic [7:0]        wr_data_i,
    output logic              rd_valid_o,
    input  logic              rd_ready_i,
    output logic [7:0]        rd_data_o,
    input  logic              eng_done_i,
    input  logic              eng_ack_i,
    input  logic [7:0]        eng_rdata_i,
    input  logic              eng_busy_i,
    output logic              eng_go_o,
    output logic              eng_unit_rst_o,
    input  logic              tmr_expired_i,
    output logic              tmr_run_o,
    output logic              tmr_restart_o,
    output rs_phase_e         phase_o,
    output logic [6:0]        dev_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ALEN_W-1:0] idx_o,
    output logic              last_o,
    output logic [7:0]        hold_o,
    output logic              done_o,
    output logic [2:0]        status_o
);
    localparam logic [ALEN_W-1:0] ALEN_MAX = ALEN_W'(MAX_ALEN);
    localparam logic [LEN_W-1:0]  ONE_LEFT = LEN_W'(1);

    typedef struct packed {
        rs_state_e         st;
        rs_phase_e         ph;
        logic [1:0]        dir;
        logic [6:0]        dev;
        logic [ADDR_W-1:0] addr;
        logic [ALEN_W-1:0] alen;
        logic [ALEN_W-1:0] idx;
        logic [LEN_W-1:0]  left;
        logic [7:0]        hold;
        logic [2:0]        code;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  pay_wr;
    logic  last_addr;

    assign pay_wr    = (r_q.dir == DIR_WRITE);
    assign last_addr = (r_q.idx == r_q.alen - 1'b1);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid_i) begin
                    r_d.dir  = cmd_dir_i;
                    r_d.dev  = cmd_dev_i;
                    r_d.addr = cmd_addr_i;
                    r_d.alen = cmd_alen_i;
                    r_d.idx  = '0;
                    r_d.code = ERR_NONE;
                    r_d.left = (cmd_dir_i == DIR_PROBE) ? ONE_LEFT : cmd_len_i;
                    if (cmd_dir_i == DIR_BAD ||
                        (cmd_dir_i != DIR_PROBE && cmd_alen_i > ALEN_MAX)) begin
                        r_d.code = ERR_ILLEGAL;
                        r_d.st   = ST_FINISH;
                    end else if (cmd_dir_i != DIR_PROBE && cmd_len_i == '0) begin
                        r_d.code = ERR_EMPTY;
                        r_d.st   = ST_FINISH;
                    end else begin
                        r_d.ph = (cmd_dir_i == DIR_PROBE) ? PH_DEVR : PH_DEVW;
                        r_d.st = ST_BUSYWT;
                    end
                end
            end
            ST_LOADWR: begin
                if (wr_valid_i) begin
                    r_d.hold = wr_data_i;
                    r_d.st   = ST_BUSYWT;
                end
            end
            ST_BUSYWT: begin
                if (!eng_busy_i) begin
                    r_d.st = ST_ISSUE;
                end else if (tmr_expired_i) begin
                    r_d.code = ERR_BUSY;
                    r_d.st   = ST_FINISH;
                end
            end
            ST_ISSUE: begin
                r_d.st = ST_WAITDN;
            end
            ST_WAITDN: begin
                if (eng_done_i) begin
                    if (r_q.ph == PH_RDATA) begin
                        r_d.hold = eng_rdata_i;
                        r_d.st   = (r_q.dir == DIR_PROBE) ? ST_FINISH : ST_RDOUT;
                    end else if (!eng_ack_i) begin
                        r_d.code = ERR_NOACK;
                        r_d.st   = ST_FINISH;
                    end else begin
                        unique case (r_q.ph)
                            PH_DEVW, PH_ADDR: begin
                                if (r_q.ph == PH_DEVW && r_q.alen != '0) begin
                                    r_d.ph = PH_ADDR;
                                    r_d.st = ST_BUSYWT;
                                end else if (r_q.ph == PH_ADDR && !last_addr) begin
                                    r_d.idx = r_q.idx + 1'b1;
                                    r_d.st  = ST_BUSYWT;
                                end else if (pay_wr) begin
                                    r_d.ph = PH_WDATA;
                                    r_d.st = ST_LOADWR;
                                end else begin
                                    r_d.ph = PH_DEVR;
                                    r_d.st = ST_BUSYWT;
                                end
                            end
                            PH_DEVR: begin
                                r_d.ph = PH_RDATA;
                                r_d.st = ST_BUSYWT;
                            end
                            default: begin
                                if (r_q.left == ONE_LEFT) begin
                                    r_d.st = ST_FINISH;
                                end else begin
                                    r_d.left = r_q.left - 1'b1;
                                    r_d.st   = ST_LOADWR;
                                end
                            end
                        endcase
                    end
                end else if (tmr_expired_i) begin
                    r_d.code = (r_q.ph == PH_RDATA) ? ERR_RXTO : ERR_TXTO;
                    r_d.st   = ST_FINISH;
                end
            end
            ST_RDOUT: begin
                if (rd_ready_i) begin
                    if (r_q.left == ONE_LEFT) begin
                        r_d.st = ST_FINISH;
                    end else begin
                        r_d.left = r_q.left - 1'b1;
                        r_d.st   = ST_BUSYWT;
                    end
                end
            end
            ST_FINISH: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.ph   <= PH_DEVW;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready_o    = (r_q.st == ST_IDLE);
    assign wr_ready_o     = (r_q.st == ST_LOADWR);
    assign rd_valid_o     = (r_q.st == ST_RDOUT);
    assign rd_data_o      = r_q.hold;
    assign eng_go_o       = (r_q.st == ST_ISSUE);
    assign done_o         = (r_q.st == ST_FINISH);
    assign status_o       = done_o ? r_q.code : ERR_NONE;
    assign eng_unit_rst_o = done_o && (r_q.code != ERR_NONE);
    assign tmr_run_o      = (r_q.st == ST_BUSYWT) || (r_q.st == ST_WAITDN);
    assign tmr_restart_o  = (r_d.st != r_q.st);
    assign phase_o        = r_q.ph;
    assign dev_o          = r_q.dev;
    assign addr_o         = r_q.addr;
    assign idx_o          = r_q.idx;
    assign last_o         = (r_q.left == ONE_LEFT);
    assign hold_o         = r_q.hold;

    AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go_o |=> !eng_go_o); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && cmd_ready_o)); // R10
    AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go_o |-> $past(!eng_busy_i)); // R7
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o))); // R11

endmodule

// File: rtl/i2c_regseq.sv
module i2c_regseq
    import i2c_regseq_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 2500000,
    parameter int MAX_ALEN       = 4,
    parameter int LEN_W          = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cmd_valid,
    output logic                           cmd_ready,
    input  logic [1:0]                     cmd_dir,
    input  logic [6:0]                     cmd_dev,
    input  logic [8*MAX_ALEN-1:0]          cmd_addr,
    input  logic [$clog2(MAX_ALEN+1)-1:0]  cmd_alen,
    input  logic [LEN_W-1:0]               cmd_len,
    input  logic                           wr_valid,
    output logic                           wr_ready,
    input  logic [7:0]                     wr_data,
    output logic                           rd_valid,
    input  logic                           rd_ready,
    output logic [7:0]                     rd_data,
    output logic                           eng_go,
    output logic                           eng_start,
    output logic                           eng_stop,
    output logic                           eng_nak,
    output logic                           eng_rd,
    output logic [7:0]                     eng_wdata,
    input  logic                           eng_done,
    input  logic                           eng_ack,
    input  logic [7:0]                     eng_rdata,
    input  logic                           eng_busy,
    output logic                           eng_unit_rst,
    output logic                           done,
    output logic [2:0]                     status
);
    localparam int ADDR_W = 8 * MAX_ALEN;
    localparam int ALEN_W = $clog2(MAX_ALEN + 1);

    rs_phase_e         phase;
    logic [6:0]        dev;
    logic [ADDR_W-1:0] addr;
    logic [ALEN_W-1:0] idx;
    logic              last;
    logic [7:0]        hold;
    logic              tmr_run, tmr_restart, tmr_expired;
    rs_byte_t          job;

    regseq_ctrl #(
        .MAX_ALEN (MAX_ALEN),
        .LEN_W    (LEN_W),
        .ADDR_W   (ADDR_W),
        .ALEN_W   (ALEN_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid_i    (cmd_valid),
        .cmd_ready_o    (cmd_ready),
        .cmd_dir_i      (cmd_dir),
        .cmd_dev_i      (cmd_dev),
        .cmd_addr_i     (cmd_addr),
        .cmd_alen_i     (cmd_alen),
        .cmd_len_i      (cmd_len),
        .wr_valid_i     (wr_valid),
        .wr_ready_o     (wr_ready),
        .wr_data_i      (wr_data),
        .rd_valid_o     (rd_valid),
        .rd_ready_i     (rd_ready),
        .rd_data_o      (rd_data),
        .eng_done_i     (eng_done),
        .eng_ack_i      (eng_ack),
        .eng_rdata_i    (eng_rdata),
        .eng_busy_i     (eng_busy),
        .eng_go_o       (eng_go),
        .eng_unit_rst_o (eng_unit_rst),
        .tmr_expired_i  (tmr_expired),
        .tmr_run_o      (tmr_run),
        .tmr_restart_o  (tmr_restart),
        .phase_o        (phase),
        .dev_o          (dev),
        .addr_o         (addr),
        .idx_o          (idx),
        .last_o         (last),
        .hold_o         (hold),
        .done_o         (done),
        .status_o       (status)
    );

    regseq_timer #(
        .LIMIT (TIMEOUT_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (tmr_run),
        .restart_i (tmr_restart),
        .expired_o (tmr_expired)
    );

    regseq_bytegen #(
        .MAX_ALEN (MAX_ALEN),
        .ALEN_W   (ALEN_W)
    ) u_bytegen (
        .phase_i (phase),
        .dev_i   (dev),
        .addr_i  (addr),
        .idx_i   (idx),
        .last_i  (last),
        .wbyte_i (hold),
        .byte_o  (job)
    );

    assign eng_wdata = job.data;
    assign eng_start = job.start;
    assign eng_stop  = job.stop;
    assign eng_nak   = job.nak;
    assign eng_rd    = job.rd;

    AST_START_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_go && eng_start) |-> (eng_wdata[7:1] == dev && !eng_rd)); // R1
    AST_NAK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_go && eng_nak) |-> (eng_rd && eng_stop)); // R3

endmodule

// File: tb/i2c_regseq_tb_top.sv
`timescale 1ns/1ps
module i2c_regseq_tb_top;
    localparam int T = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_dir = '0;
    logic [6:0] cmd_dev = '0;
    logic [31:0] cmd_addr = '0;
    logic [2:0] cmd_alen = '0;
    logic [7:0] cmd_len = '0;
    logic       wr_valid = 1'b1;
    logic       wr_ready;
    logic [7:0] wr_data = '0;
    logic       rd_valid;
    logic       rd_ready = 1'b1;
    logic [7:0] rd_data;
    logic       eng_go, eng_start, eng_stop, eng_nak, eng_rd;
    logic [7:0] eng_wdata;
    logic       eng_done = 1'b0;
    logic       eng_ack = 1'b1;
    logic [7:0] eng_rdata = '0;
    logic       eng_busy = 1'b0;
    logic       eng_unit_rst;
    logic       done;
    logic [2:0] status;

    always #2 clk = ~clk;

    i2c_regseq #(.TIMEOUT_CYCLES(T), .MAX_ALEN(4), .LEN_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_dir(cmd_dir), .cmd_dev(cmd_dev), .cmd_addr(cmd_addr), .cmd_alen(cmd_alen),
        .cmd_len(cmd_len), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .eng_go(eng_go),
        .eng_start(eng_start), .eng_stop(eng_stop), .eng_nak(eng_nak), .eng_rd(eng_rd),
        .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_ack(eng_ack),
        .eng_rdata(eng_rdata), .eng_busy(eng_busy), .eng_unit_rst(eng_unit_rst),
        .done(done), .status(status)
    );

    int checks = 0;
    int fails = 0;
    logic [11:0] log_e [64];
    logic [11:0] exp_e [64];
    int log_n = 0, exp_n = 0;
    int nak_at = -1, slow_at = -1, slow_d = 1;
    int cd = 0, cur_idx = 0;
    logic [7:0] wbuf [8];
    int wi = 0;
    bit wr_pend = 0;
    logic [7:0] rd_got [8];
    int rd_n = 0;
    bit stall = 0;
    int cyc = 0;
    bit got_done = 0;
    int got_st = 0;
    bit got_rst = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] ent(input logic [7:0] d, input logic s, input logic p,
                                        input logic n, input logic r);
        return {d, s, p, n, r};
    endfunction

    task automatic push(input logic [11:0] e);
        exp_e[exp_n] = e;
        exp_n++;
    endtask

    task automatic cmp_log(input string tag);
        chk({tag, " byte count"}, log_n, exp_n);
        for (int i = 0; i < exp_n; i++) chk({tag, " byte"}, log_e[i], exp_e[i]);
    endtask

    // engine model, write feeder, read consumer and done capture
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (eng_done) eng_done = 1'b0;
            if (eng_unit_rst) begin
                cd = 0;
            end else if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    eng_done  = 1'b1;
                    eng_ack   = (cur_idx != nak_at);
                    eng_rdata = 8'h5A ^ 8'(cur_idx);
                end
            end
            if (eng_go) begin
                log_e[log_n] = {eng_wdata, eng_start, eng_stop, eng_nak, eng_rd};
                cur_idx = log_n;
                cd = (log_n == slow_at) ? slow_d : 1;
                log_n++;
            end
            if (wr_pend) wi++;
            wr_data = wbuf[wi];
            wr_pend = wr_valid && wr_ready;
            rd_ready = stall ? ((cyc % 3) == 2) : 1'b1;
            if (rd_valid && rd_ready) begin
                rd_got[rd_n] = rd_data;
                rd_n++;
            end
            if (done) begin
                got_done = 1'b1;
                got_st   = status;
                got_rst  = eng_unit_rst;
            end
        end
    end

    task automatic run_cmd(input logic [1:0] dir, input logic [6:0] dev, input logic [31:0] addr,
                           input logic [2:0] alen, input logic [7:0] len);
        @(negedge clk);
        log_n = 0; exp_n = 0; rd_n = 0; wi = 0; got_done = 0; got_rst = 0;
        cmd_valid = 1'b1; cmd_dir = dir; cmd_dev = dev; cmd_addr = addr;
        cmd_alen = alen; cmd_len = len;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < 3000 && !got_done; k++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic end_knobs;
        nak_at = -1; slow_at = -1; slow_d = 1; stall = 0; eng_busy = 1'b0;
    endtask

    task automatic t_reset;
        chk("R10 reset cmd_ready", cmd_ready, 1);
        chk("R10 reset done", done, 0);
        chk("R12 reset go", eng_go, 0);
        chk("R11 reset rd_valid", rd_valid, 0);
        chk("R10 reset unit_rst", eng_unit_rst, 0);
    endtask

    task automatic t_write_two_addr;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        run_cmd(2'd0, 7'h50, 32'h1234BEEF, 3'd2, 8'd3);
        push(ent(8'hA0, 1, 0, 0, 0));
        push(ent(8'hEF, 0, 0, 0, 0));
        push(ent(8'hBE, 0, 0, 0, 0));
        push(ent(8'h11, 0, 0, 0, 0));
        push(ent(8'h22, 0, 0, 0, 0));
        push(ent(8'h33, 0, 1, 0, 0));
        cmp_log("R1 R2 R4 write");
        chk("R10 write status", got_st, 0);
        chk("R10 write no unit reset", got_rst, 0);
        end_knobs();
    endtask

    task automatic t_read_stall;
        stall = 1;
        run_cmd(2'd1, 7'h3C, 32'h00000077, 3'd1, 8'd3);
        push(ent(8'h78, 1, 0, 0, 0));
        push(ent(8'h77, 0, 0, 0, 0));
        push(ent(8'h79, 1, 0, 0, 0));
        push(ent(8'h00, 0, 0, 0, 1));
        push(ent(8'h00, 0, 0, 0, 1));
        push(ent(8'h00, 0, 1, 1, 1));
        cmp_log("R3 read bytes");
        chk("R11 read count", rd_n, 3);
        chk("R11 read data0", rd_got[0], 8'h5A ^ 8'd3);
        chk("R11 read data1", rd_got[1], 8'h5A ^ 8'd4);
        chk("R11 read data2", rd_got[2], 8'h5A ^ 8'd5);
        chk("R3 read status", got_st, 0);
        end_knobs();
    endtask

    task automatic t_read_noaddr;
        run_cmd(2'd1, 7'h11, 32'hFFFFFFFF, 3'd0, 8'd1);
        push(ent(8'h22, 1, 0, 0, 0));
        push(ent(8'h23, 1, 0, 0, 0));
        push(ent(8'h00, 0, 1, 1, 1));
        cmp_log("R2 R3 read zero address bytes");
        chk("R11 single read data", rd_got[0], 8'h5A ^ 8'd2);
        chk("R3 single read status", got_st, 0);
        end_knobs();
    endtask

    task automatic t_write_four_addr;
        wbuf[0] = 8'h9E;
        run_cmd(2'd0, 7'h2A, 32'hA1B2C3D4, 3'd4, 8'd1);
        push(ent(8'h54, 1, 0, 0, 0));
        push(ent(8'hD4, 0, 0, 0, 0));
        push(ent(8'hC3, 0, 0, 0, 0));
        push(ent(8'hB2, 0, 0, 0, 0));
        push(ent(8'hA1, 0, 0, 0, 0));
        push(ent(8'h9E, 0, 1, 0, 0));
        cmp_log("R2 four address bytes lowest first");
        chk("R4 four-address status", got_st, 0);
        end_knobs();
    endtask

    task automatic t_probe_ok;
        run_cmd(2'd2, 7'h48, 32'h0, 3'd7, 8'd0);
        push(ent(8'h91, 1, 0, 0, 0));
        push(ent(8'h00, 0, 1, 1, 1));
        cmp_log("R5 probe bytes");
        chk("R5 probe status", got_st, 0);
        chk("R5 probe no read stream", rd_n, 0);
        end_knobs();
    endtask

    task automatic t_nak_addr;
        nak_at = 2;
        run_cmd(2'd0, 7'h50, 32'h00000302, 3'd2, 8'd2);
        push(ent(8'hA0, 1, 0, 0, 0));
        push(ent(8'h02, 0, 0, 0, 0));
        push(ent(8'h03, 0, 0, 0, 0));
        cmp_log("R6 abort after missing ACK");
        chk("R6 missing ACK status", got_st, 3);
        chk("R10 unit reset on NAK", got_rst, 1);
        end_knobs();
    endtask

    task automatic t_probe_absent;
        nak_at = 0;
        run_cmd(2'd2, 7'h0F, 32'h0, 3'd0, 8'd0);
        chk("R5 absent probe bytes", log_n, 1);
        chk("R5 absent probe status", got_st, 3);
        end_knobs();
    endtask

    task automatic t_busy;
        eng_busy = 1'b1;
        run_cmd(2'd2, 7'h48, 32'h0, 3'd0, 8'd0);
        chk("R7 busy no byte", log_n, 0);
        chk("R7 busy status", got_st, 6);
        chk("R10 unit reset on busy", got_rst, 1);
        eng_busy = 1'b1;
        fork
            run_cmd(2'd2, 7'h48, 32'h0, 3'd0, 8'd0);
            begin
                repeat (8) @(negedge clk);
                eng_busy = 1'b0;
            end
        join
        chk("R7 busy released bytes", log_n, 2);
        chk("R7 busy released status", got_st, 0);
        end_knobs();
    endtask

    task automatic t_timeout_edge;
        wbuf[0] = 8'h42;
        slow_at = 0; slow_d = T;
        run_cmd(2'd0, 7'h50, 32'h0, 3'd0, 8'd1);
        chk("R8 completion on last window cycle bytes", log_n, 2);
        chk("R8 completion on last window cycle status", got_st, 0);
        slow_at = 0; slow_d = T + 1;
        run_cmd(2'd0, 7'h50, 32'h0, 3'd0, 8'd1);
        chk("R8 tx timeout bytes", log_n, 1);
        chk("R8 tx timeout status", got_st, 2);
        chk("R10 unit reset on tx timeout", got_rst, 1);
        end_knobs();
    endtask

    task automatic t_rx_timeout;
        slow_at = 2; slow_d = T + 1;
        run_cmd(2'd1, 7'h33, 32'h0, 3'd0, 8'd2);
        chk("R8 rx timeout bytes", log_n, 3);
        chk("R8 rx timeout status", got_st, 4);
        chk("R11 rx timeout no read data", rd_n, 0);
        end_knobs();
    endtask

    task automatic t_bad_cmds;
        run_cmd(2'd3, 7'h50, 32'h0, 3'd1, 8'd1);
        chk("R9 illegal dir status", got_st, 5);
        chk("R9 illegal dir no byte", log_n, 0);
        chk("R10 unit reset on illegal", got_rst, 1);
        run_cmd(2'd0, 7'h50, 32'h0, 3'd5, 8'd1);
        chk("R9 long address status", got_st, 5);
        chk("R9 long address no byte", log_n, 0);
        run_cmd(2'd1, 7'h50, 32'h0, 3'd1, 8'd0);
        chk("R9 empty read status", got_st, 1);
        chk("R9 empty read no byte", log_n, 0);
        end_knobs();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) wbuf[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_two_addr();
        t_read_stall();
        t_read_noaddr();
        t_write_four_addr();
        t_probe_ok();
        t_nak_addr();
        t_probe_absent();
        t_busy();
        t_timeout_edge();
        t_rx_timeout();
        t_bad_cmds();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule